// File: doc/BRIEF.md
# Half-Bridge PWM Command Conditioner

This block sits between the controller's two PWM commands for a half-bridge (one for the upper switch, one for the lower) and the two gate channels. Each command is first brought into the clock domain by a two-flop synchroniser. It then passes a glitch filter that drops any pulse too short to be real. The result goes to an arbitration state machine, which never lets both conditioned commands be active together and keeps a programmable idle gap between one side turning off and the other turning on.

Two modes are provided. In direct mode the two commands are independent and the external controller is expected to place the dead-time itself. The block then adds delay only when the commands really come closer than the programmed gap. In single-input mode (`single_in_mode` = 1) only the upper command is used. The lower conditioned command is its complement, and a dead-time is inserted before every turn-on. The lower input has no effect in this mode. All durations are clock-cycle counts on input ports. At a 100 MHz clock, typical settings are 5 cycles of glitch width and 20 cycles of overlap gap.

The filter has two states. FLT_STEADY moves to FLT_QUALIFY when the input first differs from the filtered value. FLT_QUALIFY returns to FLT_STEADY on a commit or when the input falls back. The arbiter has three states. ARB_IDLE means both commands are off. ARB_HIGH means the upper command is on, and ARB_LOW means the lower command is on. Its transitions are:
- IDLE→HIGH or IDLE→LOW on an exclusive request once the gap is met.
- HIGH→IDLE or LOW→IDLE when the request drops.
- HIGH→LOW or LOW→HIGH as a direct swap, only when the selected gap is zero.

Top module: `hb_pwm_conditioner`

## Requirements
- R1: While `rst_n` is low, and right after it is released, both `gate_hi_cmd` and `gate_lo_cmd` are 0.
- R2: With glitch width G (`glitch_cyc`), a high or low pulse on an input that lasts G clock cycles or fewer leaves the conditioned output unchanged. A longer pulse appears with its width preserved. With G = 0 the filter is bypassed.
- R3: An accepted input edge reaches its conditioned output G+4 clock edges after the first edge that samples it: two synchroniser flops, G+1 filter edges, and the output register.
- R4: `gate_hi_cmd` and `gate_lo_cmd` are never 1 in the same cycle.
- R5: In direct mode with gap P (`novp_cyc`), the turn-on of one side that follows the turn-off of the other happens after at least P cycles with both outputs low. If the filtered inputs already leave r ≥ P idle cycles, no delay is added. The turn-on comes L+max(r,P) edges after the falling input edge, where L = G+4. P = 0 allows a same-cycle swap.
- R6: In direct mode, if both inputs request from the idle state, both outputs stay low until exactly one request remains.
- R7: In single-input mode, `gate_lo_cmd` is the complement of the upper command and `pwm_lo_in` is ignored. Each turn-on follows the opposite turn-off after D cycles (`novd_cyc`), so it comes L+D edges after the input edge. D = 0 gives a direct swap.
- R8: A change of `single_in_mode` is taken into use only in a cycle where both outputs are low. While one output stays on, the previous mode keeps governing.
- R9: Turning the same side on again after it went off needs no gap. The gap applies only between opposite sides.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi_in | input | 1 | Upper-switch PWM command, asynchronous |
| pwm_lo_in | input | 1 | Lower-switch PWM command, asynchronous |
| single_in_mode | input | 1 | 1 = complementary commands built from `pwm_hi_in`; 0 = direct mode |
| glitch_cyc | input | CNT_W | Glitch width G in cycles |
| novp_cyc | input | CNT_W | Direct-mode minimum gap P in cycles |
| novd_cyc | input | CNT_W | Single-input-mode dead-time D in cycles |
| gate_hi_cmd | output | 1 | Conditioned upper command, registered |
| gate_lo_cmd | output | 1 | Conditioned lower command, registered |

## Verification
The assertions assume that the three duration inputs are held steady while commands are moving. The gap and filter checks compare against the current settings, so a duration changed mid-pulse could be reported falsely. The bench therefore loads each configuration and then pulses reset before driving any edge. It changes only the mode select during operation, and the mode-change case uses equal direct and single-input gaps. Inputs change half a clock period away from the sampling edge, so the synchroniser count in R3 stays exact.

// File: rtl/hbpc_pkg.sv
package hbpc_pkg;
    typedef enum logic {
        FLT_STEADY,
        FLT_QUALIFY
    } flt_state_t;

    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_HIGH = 2'd1,
        ARB_LOW  = 2'd2
    } arb_state_t;

    localparam int CH_LO  = 0;
    localparam int CH_HI  = 1;
    localparam int N_CH   = 2;
endpackage

// File: rtl/hbpc_sync.sv
module hbpc_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
    end

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/hbpc_deglitch.sv
module hbpc_deglitch
    import hbpc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             filt_o
);
    flt_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             filt_q, take;

    // next-state decode
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        take  = 1'b0;
        unique case (st_q)
            FLT_STEADY: begin
                if (raw_i != filt_q) begin
                    if (width_i == '0) begin
                        take = 1'b1;
                    end else begin
                        st_d  = FLT_QUALIFY;
                        cnt_d = CNT_W'(1);
                    end
                end
            end
            FLT_QUALIFY: begin
                if (raw_i == filt_q) begin
                    st_d  = FLT_STEADY;
                    cnt_d = '0;
                end else if (cnt_q >= width_i) begin
                    take  = 1'b1;
                    st_d  = FLT_STEADY;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                st_d  = FLT_STEADY;
                cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= FLT_STEADY;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    filt_q <= 1'b0;
        else if (take) filt_q <= ~filt_q;
    end

    assign filt_o = filt_q;

    // a committed value must be the one the raw input carried
    AST_FILTER_SETTLED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> (filt_q == $past(raw_i))); // R2

    // with a nonzero width, a commit needs the raw input to disagree on two successive edges
    AST_FILTER_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(filt_q) && width_i != '0) |-> ($past(raw_i, 2) == filt_q)); // R2
endmodule

// File: rtl/hbpc_arbiter.sv
module hbpc_arbiter
    import hbpc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fh_i,
    input  logic             fl_i,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] novp_i,
    input  logic [CNT_W-1:0] novd_i,
    output logic             hi_o,
    output logic             lo_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    arb_state_t       st_q, st_d;
    logic [CNT_W-1:0] gap_cnt_q, gap_cnt_d;
    logic             last_hi_q, last_lo_q;
    logic             mode_q;
    logic             hi_q, lo_q;

    logic             req_h, req_l;
    logic [CNT_W-1:0] gap_sel;
    logic [CNT_W:0]   idle_plus;
    logic             gap_met;

    assign req_h     = fh_i;
    assign req_l     = mode_q ? ~fh_i : fl_i;
    assign gap_sel   = mode_q ? novd_i : novp_i;
    assign idle_plus = {1'b0, gap_cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    assign gap_met   = idle_plus >= {1'b0, gap_sel};

    // next-state decode
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARB_IDLE: begin
                if (req_h && !req_l && (!last_lo_q || gap_met))
                    st_d = ARB_HIGH;
                else if (req_l && !req_h && (!last_hi_q || gap_met))
                    st_d = ARB_LOW;
            end
            ARB_HIGH: begin
                if (!req_h)
                    st_d = (req_l && gap_sel == '0) ? ARB_LOW : ARB_IDLE;
            end
            ARB_LOW: begin
                if (!req_l)
                    st_d = (req_h && gap_sel == '0) ? ARB_HIGH : ARB_IDLE;
            end
            default: st_d = ARB_IDLE;
        endcase
    end

    always_comb begin
        gap_cnt_d = gap_cnt_q;
        if (st_q != ARB_IDLE)        gap_cnt_d = '0;
        else if (gap_cnt_q != CNT_MAX) gap_cnt_d = gap_cnt_q + CNT_W'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= ARB_IDLE;
            gap_cnt_q <= '0;
            last_hi_q <= 1'b0;
            last_lo_q <= 1'b0;
            mode_q    <= 1'b0;
        end else begin
            st_q      <= st_d;
            gap_cnt_q <= gap_cnt_d;
            if (st_q == ARB_HIGH) begin
                last_hi_q <= 1'b1;
                last_lo_q <= 1'b0;
            end else if (st_q == ARB_LOW) begin
                last_hi_q <= 1'b0;
                last_lo_q <= 1'b1;
            end
            if (st_q == ARB_IDLE) mode_q <= mode_i;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= (st_d == ARB_HIGH);
            lo_q <= (st_d == ARB_LOW);
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;

    // observation-only counters for the gap checks
    logic [CNT_W-1:0] chk_idle_q;
    logic             chk_side_hi_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_idle_q    <= '0;
            chk_side_hi_q <= 1'b0;
        end else begin
            if (hi_q || lo_q)              chk_idle_q <= '0;
            else if (chk_idle_q != CNT_MAX) chk_idle_q <= chk_idle_q + CNT_W'(1);
            if (hi_q)      chk_side_hi_q <= 1'b1;
            else if (lo_q) chk_side_hi_q <= 1'b0;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_q && lo_q)); // R4

    AST_GAP_BEFORE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_q) && chk_side_hi_q && $past(gap_sel) != '0) |-> (chk_idle_q >= $past(gap_sel))); // R5

    AST_GAP_BEFORE_HI: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(hi_q) && !chk_side_hi_q && $past(lo_q, 2) && $past(gap_sel) != '0)
            |-> (chk_idle_q >= $past(gap_sel))); // R5

    AST_BOTH_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && fh_i && fl_i && !hi_q && !lo_q) |=> (!hi_q && !lo_q)); // R6

    AST_LOCAL_LOW_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(lo_q) && $past(mode_q)) |-> $past(!fh_i)); // R7

    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(!hi_q && !lo_q)); // R8
endmodule

// File: rtl/hb_pwm_conditioner.sv
module hb_pwm_conditioner
    import hbpc_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_hi_in,
    input  logic             pwm_lo_in,
    input  logic             single_in_mode,
    input  logic [CNT_W-1:0] glitch_cyc,
    input  logic [CNT_W-1:0] novp_cyc,
    input  logic [CNT_W-1:0] novd_cyc,
    output logic             gate_hi_cmd,
    output logic             gate_lo_cmd
);
    logic [N_CH-1:0] raw_in, raw_sync, filt;

    assign raw_in[CH_HI] = pwm_hi_in;
    assign raw_in[CH_LO] = pwm_lo_in;

    hbpc_sync #(.W(N_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (raw_sync)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_flt
        hbpc_deglitch #(.CNT_W(CNT_W)) u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_sync[ch]),
            .width_i (glitch_cyc),
            .filt_o  (filt[ch])
        );
    end

    hbpc_arbiter #(.CNT_W(CNT_W)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .fh_i   (filt[CH_HI]),
        .fl_i   (filt[CH_LO]),
        .mode_i (single_in_mode),
        .novp_i (novp_cyc),
        .novd_i (novd_cyc),
        .hi_o   (gate_hi_cmd),
        .lo_o   (gate_lo_cmd)
    );

    AST_OUT_LOW_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!gate_hi_cmd && !gate_lo_cmd)); // R1
endmodule

// File: tb/sim_hb_pwm_conditioner.sv
`timescale 1ns/1ps
module sim_hb_pwm_conditioner;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hi_in = 1'b0, lo_in = 1'b0, mode = 1'b0;
    logic [CW-1:0] g_cyc = '0, p_cyc = '0, d_cyc = '0;
    logic          hi_cmd, lo_cmd;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    hb_pwm_conditioner #(.CNT_W(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .pwm_hi_in(hi_in), .pwm_lo_in(lo_in),
        .single_in_mode(mode), .glitch_cyc(g_cyc), .novp_cyc(p_cyc),
        .novd_cyc(d_cyc), .gate_hi_cmd(hi_cmd), .gate_lo_cmd(lo_cmd)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic m, input int g, input int p, input int d);
        @(negedge clk);
        rst_n = 1'b0;
        hi_in = 1'b0; lo_in = 1'b0; mode = m;
        g_cyc = CW'(g); p_cyc = CW'(p); d_cyc = CW'(d);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1: reset state with inputs driven high
        hi_in = 1'b1; lo_in = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 hi in reset", int'(hi_cmd), 0);
        check("R1 lo in reset", int'(lo_cmd), 0);
        do_reset(1'b0, 0, 0, 0);
        check("R1 hi after reset", int'(hi_cmd), 0);
        check("R1 lo after reset", int'(lo_cmd), 0);

        // R2/R3: glitch sweep, both polarities
        for (int g = 0; g <= 3; g++) begin
            do_reset(1'b0, g, 2, 0);
            for (int w = 1; w <= g + 2; w++) begin
                int cnt, first;
                cnt = 0; first = -1;
                hi_in = 1'b1;
                for (int t = 1; t <= g + w + 8; t++) begin
                    @(negedge clk);
                    if (t == w) hi_in = 1'b0;
                    if (hi_cmd) begin cnt++; if (first < 0) first = t; end
                end
                check("R2 high pulse width", cnt, (w > g) ? w : 0);
                if (w > g) check("R3 rise latency", first, g + 4);
                hi_in = 1'b1;
                repeat (g + 8) @(negedge clk);
                cnt = 0; first = -1;
                hi_in = 1'b0;
                for (int t = 1; t <= g + w + 8; t++) begin
                    @(negedge clk);
                    if (t == w) hi_in = 1'b1;
                    if (!hi_cmd) begin cnt++; if (first < 0) first = t; end
                end
                check("R2 low pulse width", cnt, (w > g) ? w : 0);
                if (w > g) check("R3 fall latency", first, g + 4);
                hi_in = 1'b0;
                repeat (g + 8) @(negedge clk);
            end
        end

        // R5/R4: direct-mode gap sweep, G=1 so L=5
        for (int p = 0; p <= 3; p++) begin
            for (int r = 0; r <= 4; r++) begin
                int lofall, hirise, ovl;
                do_reset(1'b0, 1, p, 0);
                lo_in = 1'b1;
                repeat (10) @(negedge clk);
                check("R5 lo on before swap", int'(lo_cmd), 1);
                lofall = -1; hirise = -1; ovl = 0;
                lo_in = 1'b0;
                if (r == 0) hi_in = 1'b1;
                for (int t = 1; t <= 25; t++) begin
                    @(negedge clk);
                    if (t == r) hi_in = 1'b1;
                    if (!lo_cmd && lofall < 0) lofall = t;
                    if (hi_cmd && hirise < 0) hirise = t;
                    if (hi_cmd && lo_cmd) ovl++;
                end
                check("R5 lo fall time", lofall, 5);
                check("R5 hi rise time", hirise, 5 + ((r > p) ? r : p));
                check("R4 overlap cycles", ovl, 0);
            end
        end

        // R6: both requested from idle
        begin
            int any_on, hirise;
            do_reset(1'b0, 0, 2, 0);
            any_on = 0; hirise = -1;
            hi_in = 1'b1; lo_in = 1'b1;
            for (int t = 1; t <= 12; t++) begin
                @(negedge clk);
                if (hi_cmd || lo_cmd) any_on++;
            end
            check("R6 both held off", any_on, 0);
            lo_in = 1'b0;
            for (int t = 1; t <= 10; t++) begin
                @(negedge clk);
                if (hi_cmd && hirise < 0) hirise = t;
            end
            check("R6 hi rise after lo release", hirise, 4);
        end

        // R9: same-side re-assert ignores the gap (G=0, P=3)
        begin
            int at10, at11;
            do_reset(1'b0, 0, 3, 0);
            at10 = -1; at11 = -1;
            hi_in = 1'b1;
            for (int t = 1; t <= 14; t++) begin
                @(negedge clk);
                if (t == 6) hi_in = 1'b0;
                if (t == 7) hi_in = 1'b1;
                if (t == 10) at10 = int'(hi_cmd);
                if (t == 11) at11 = int'(hi_cmd);
            end
            check("R9 gap cycle low", at10, 0);
            check("R9 re-rise without gap", at11, 1);
        end

        // R7: single-input mode, dead-time sweep, lo input toggling
        for (int d = 0; d <= 3; d++) begin
            int lofall, hirise, hifall, lorise, ovl;
            do_reset(1'b1, 1, 0, d);
            repeat (12) @(negedge clk);
            check("R7 idle lo on", int'(lo_cmd), 1);
            check("R7 idle hi off", int'(hi_cmd), 0);
            lofall = -1; hirise = -1; ovl = 0;
            hi_in = 1'b1;
            for (int t = 1; t <= 20; t++) begin
                @(negedge clk);
                lo_in = t[0];
                if (!lo_cmd && lofall < 0) lofall = t;
                if (hi_cmd && hirise < 0) hirise = t;
                if (hi_cmd && lo_cmd) ovl++;
            end
            check("R7 lo off time", lofall, 5);
            check("R7 hi on time", hirise, 5 + d);
            hifall = -1; lorise = -1;
            hi_in = 1'b0;
            for (int t = 1; t <= 20; t++) begin
                @(negedge clk);
                lo_in = ~t[0];
                if (!hi_cmd && hifall < 0) hifall = t;
                if (lo_cmd && lorise < 0) lorise = t;
                if (hi_cmd && lo_cmd) ovl++;
            end
            check("R7 hi off time", hifall, 5);
            check("R7 lo on time", lorise, 5 + d);
            check("R4 overlap local", ovl, 0);
            lo_in = 1'b0;
        end

        // R8: mode change deferred while an output stays on
        begin
            int lo_held;
            do_reset(1'b1, 0, 2, 2);
            repeat (10) @(negedge clk);
            mode = 1'b0;
            lo_held = 0;
            for (int t = 1; t <= 20; t++) begin
                @(negedge clk);
                if (lo_cmd) lo_held++;
            end
            check("R8 lo kept under old mode", lo_held, 20);
            hi_in = 1'b1;
            repeat (30) @(negedge clk);
            check("R8 hi on after idle", int'(hi_cmd), 1);
            hi_in = 1'b0;
            repeat (30) @(negedge clk);
            check("R8 direct mode lo off", int'(lo_cmd), 0);
            check("R8 direct mode hi off", int'(hi_cmd), 0);
            lo_in = 1'b1;
            repeat (30) @(negedge clk);
            check("R8 direct mode lo follows input", int'(lo_cmd), 1);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule